// File: doc/BRIEF.md
# Multi-Port GPIO Data Register Bank

This block holds a set of 8-bit port data registers behind a simple memory-mapped bus. Each port owns an output latch that drives the pin while the bit is set to output. A bus read returns a per-bit choice. Output-mode bits return the latch value. Input-mode bits return the pin level, which passes through a two-flop synchronizer first. A bit whose analog-select input is high reads as zero whenever its value would come from the pin.

Each port is placed at `BASE_ADDR` plus its index. Parameters set which ports exist and, for each port, which bits are implemented and which bits are read-only pins. Unimplemented bits hold zero. Read-only bits ignore writes and always report the pin. Software can update one bit through a strobe with an index and a value, or replace the whole byte.

Top module: `gpio_bank`

## Requirements
- R1: After reset every latch bit on `latch_out` is 0, and a read of any port address returns 00h while all pins are low.
- R2: A byte write (`wr_en`=1) to a present port loads `wr_data` into every implemented, writable latch bit, and the new value appears on `latch_out` after one clock edge. If `wr_en` and `bit_wr` are both high in the same cycle, only the byte write takes effect. With no write strobe, the latches hold their value.
- R3: A read bit whose `dir_in` is 0 (output mode), that is implemented and writable, returns its latch value.
- R4: A read bit whose `dir_in` is 1 (input mode) returns the level `pin_in` had two rising clock edges earlier. A change on a pin is not visible after a single edge.
- R5: A read bit that takes its value from the pin (input mode or read-only) returns 0 while its `analog_sel` bit is 1. An output-mode bit is not affected by `analog_sel`.
- R6: A bit write (`bit_wr`=1) sets latch bit `bit_idx` (0 = LSB) of the addressed port to `bit_val` and leaves the other seven bits unchanged.
- R7: Bits outside a port's implemented mask always read 0, and their `latch_out` bits stay 0 under any write.
- R8: Read-only bits ignore byte and bit writes, so their latch stays 0. A read returns their pin level regardless of `dir_in`.
- R9: An address with no present port, whether outside the range or a gap inside it, reads 00h, and a write to it changes no latch.
- R10: Port k is decoded at address `BASE_ADDR`+k, and at most one port is selected at a time.
- R11: `rd_data` is combinational and is valid in the same cycle as `rd_en`. It is 00h while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Bus byte address |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit index for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, same cycle as `rd_en` |
| dir_in | input | NUM_PORTS*8 | Per-bit direction, 1 = input |
| analog_sel | input | NUM_PORTS*8 | Per-bit analog select |
| pin_in | input | NUM_PORTS*8 | Asynchronous pin levels |
| latch_out | output | NUM_PORTS*8 | Output latch values toward the pin drivers |

## Verification
Assertions check four properties on every cycle. Latches hold when nothing writes to them. A bit write moves no other bit. Unimplemented and read-only latch bits never change. Analog bits on the pin path, unused addresses and idle reads all return zero. Only the bench scenarios can show the actual data paths: the value a byte or bit write leaves behind, the two-edge pin delay, the address-to-port mapping, and the mixed direction and analog patterns read back against an arithmetic model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int PORT_W    = 8;
   localparam int BIT_IDX_W = 3;

   function automatic logic [PORT_W-1:0] bit_onehot(input logic [BIT_IDX_W-1:0] idx);
      logic [PORT_W-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage1_q;
   logic [WIDTH-1:0] stage2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= async_in;
         stage2_q <= stage1_q;
      end
   end

   assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
   parameter int                 ADDR_W       = 8,
   parameter int                 NUM_PORTS    = 4,
   parameter logic [ADDR_W-1:0]  BASE_ADDR    = '0,
   parameter logic [NUM_PORTS-1:0] PORT_PRESENT = '1
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_PORTS-1:0] sel,
   output logic                 hit
);
   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(int'(BASE_ADDR) + k);
      if (PORT_PRESENT[k]) begin : g_present
         assign sel[k] = (addr == SLOT_ADDR);
      end else begin : g_absent
         assign sel[k] = 1'b0;
      end
   end

   assign hit = |sel;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_bank_pkg::*;
#(
   parameter logic [PORT_W-1:0] IMPL_BITS = '1,
   parameter logic [PORT_W-1:0] RO_BITS   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 byte_we,
   input  logic [PORT_W-1:0]    byte_data,
   input  logic                 bit_we,
   input  logic [BIT_IDX_W-1:0] bit_idx,
   input  logic                 bit_val,
   input  logic [PORT_W-1:0]    dir_in,
   input  logic [PORT_W-1:0]    analog,
   input  logic [PORT_W-1:0]    pin_sync,
   output logic [PORT_W-1:0]    latch_q,
   output logic [PORT_W-1:0]    rd_word
);
   localparam logic [PORT_W-1:0] WR_BITS = IMPL_BITS & ~RO_BITS;

   logic [PORT_W-1:0] bit_mask;
   assign bit_mask = bit_onehot(bit_idx) & WR_BITS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (sel && byte_we) begin
         latch_q <= (latch_q & ~WR_BITS) | (byte_data & WR_BITS);
      end else if (sel && bit_we) begin
         latch_q <= (latch_q & ~bit_mask) | ({PORT_W{bit_val}} & bit_mask);
      end
   end

   for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      if (!IMPL_BITS[b]) begin : g_absent
         assign rd_word[b] = 1'b0;
      end else if (RO_BITS[b]) begin : g_pin_only
         assign rd_word[b] = pin_sync[b] & ~analog[b];
      end else begin : g_rw
         assign rd_word[b] = dir_in[b] ? (pin_sync[b] & ~analog[b]) : latch_q[b];
      end
   end

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && (byte_we || bit_we)) |=> $stable(latch_q));

   assert_bit_write_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && bit_we && !byte_we) |=>
      (((latch_q ^ $past(latch_q)) & ~bit_onehot($past(bit_idx))) == '0));

   // R7 as well: unimplemented bits are outside WR_BITS
   assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && (byte_we || bit_we)) |=> (((latch_q ^ $past(latch_q)) & ~WR_BITS) == '0));

   assert_analog_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_word & analog & (dir_in | RO_BITS)) == '0);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int                       NUM_PORTS    = 4,
   parameter int                       ADDR_W       = 8,
   parameter logic [ADDR_W-1:0]        BASE_ADDR    = 8'h10,
   parameter logic [NUM_PORTS-1:0]     PORT_PRESENT = 4'b1011,
   parameter logic [NUM_PORTS*8-1:0]   IMPL_MASK    = 32'h9F00_FF7F,
   parameter logic [NUM_PORTS*8-1:0]   RO_MASK      = 32'h1E00_0000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr_en,
   input  logic [7:0]               wr_data,
   input  logic                     bit_wr,
   input  logic [2:0]               bit_idx,
   input  logic                     bit_val,
   input  logic                     rd_en,
   output logic [7:0]               rd_data,
   input  logic [NUM_PORTS*8-1:0]   dir_in,
   input  logic [NUM_PORTS*8-1:0]   analog_sel,
   input  logic [NUM_PORTS*8-1:0]   pin_in,
   output logic [NUM_PORTS*8-1:0]   latch_out
);
   localparam int TOTAL_BITS = NUM_PORTS * PORT_W;
   localparam int LAST_SLOT  = int'(BASE_ADDR) + NUM_PORTS - 1;

   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("gpio_bank: NUM_PORTS must be at least 1");
   end
   if (LAST_SLOT >= (1 << ADDR_W)) begin : g_chk_range
      $error("gpio_bank: port range exceeds address space");
   end
   if ((RO_MASK & ~IMPL_MASK) != '0) begin : g_chk_ro
      $error("gpio_bank: read-only bits must be implemented bits");
   end

   logic [NUM_PORTS-1:0]             sel;
   logic                             hit;
   logic [TOTAL_BITS-1:0]            pin_sync;
   logic [NUM_PORTS-1:0][PORT_W-1:0] rd_word;

   gpio_addr_dec #(
      .ADDR_W       (ADDR_W),
      .NUM_PORTS    (NUM_PORTS),
      .BASE_ADDR    (BASE_ADDR),
      .PORT_PRESENT (PORT_PRESENT)
   ) u_dec (
      .addr (addr),
      .sel  (sel),
      .hit  (hit)
   );

   gpio_sync #(.WIDTH(TOTAL_BITS)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      if (PORT_PRESENT[k]) begin : g_real
         gpio_port #(
            .IMPL_BITS (IMPL_MASK[k*PORT_W +: PORT_W]),
            .RO_BITS   (RO_MASK[k*PORT_W +: PORT_W])
         ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel[k]),
            .byte_we   (wr_en),
            .byte_data (wr_data),
            .bit_we    (bit_wr),
            .bit_idx   (bit_idx),
            .bit_val   (bit_val),
            .dir_in    (dir_in[k*PORT_W +: PORT_W]),
            .analog    (analog_sel[k*PORT_W +: PORT_W]),
            .pin_sync  (pin_sync[k*PORT_W +: PORT_W]),
            .latch_q   (latch_out[k*PORT_W +: PORT_W]),
            .rd_word   (rd_word[k])
         );
      end else begin : g_hole
         assign latch_out[k*PORT_W +: PORT_W] = '0;
         assign rd_word[k] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         if (rd_en && sel[k]) rd_data = rd_data | rd_word[k];
      end
   end

   assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   assert_unused_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |-> (rd_data == 8'h00));

   assert_unused_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || bit_wr) && !hit) |=> $stable(latch_out));

   assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == 8'h00));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
   localparam int               CLK_PERIOD = 10;
   localparam int               NP         = 4;
   localparam int               AW         = 8;
   localparam logic [AW-1:0]    BASE       = 8'h10;
   localparam logic [NP-1:0]    PRESENT    = 4'b1011;
   localparam logic [NP*8-1:0]  IMPL       = 32'h9F00_FF7F;
   localparam logic [NP*8-1:0]  RO         = 32'h1E00_0000;

   logic            clk;
   logic            rst_n;
   logic [AW-1:0]   addr;
   logic            wr_en;
   logic [7:0]      wr_data;
   logic            bit_wr;
   logic [2:0]      bit_idx;
   logic            bit_val;
   logic            rd_en;
   logic [7:0]      rd_data;
   logic [NP*8-1:0] dir_in;
   logic [NP*8-1:0] analog_sel;
   logic [NP*8-1:0] pin_in;
   logic [NP*8-1:0] latch_out;

   int checks = 0;
   int errors = 0;
   logic [7:0] mdl [NP];

   gpio_bank #(
      .NUM_PORTS    (NP),
      .ADDR_W       (AW),
      .BASE_ADDR    (BASE),
      .PORT_PRESENT (PRESENT),
      .IMPL_MASK    (IMPL),
      .RO_MASK      (RO)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .bit_wr     (bit_wr),
      .bit_idx    (bit_idx),
      .bit_val    (bit_val),
      .rd_en      (rd_en),
      .rd_data    (rd_data),
      .dir_in     (dir_in),
      .analog_sel (analog_sel),
      .pin_in     (pin_in),
      .latch_out  (latch_out)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int port_of(input logic [AW-1:0] a);
      int p;
      p = int'(a) - int'(BASE);
      if (p < 0 || p >= NP) return -1;
      if (!PRESENT[p]) return -1;
      return p;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [AW-1:0] a, input logic [NP*8-1:0] pins);
      logic [7:0] v;
      int p;
      v = 8'h00;
      p = port_of(a);
      if (p < 0) return v;
      for (int b = 0; b < 8; b++) begin
         int i;
         i = p * 8 + b;
         if (!IMPL[i]) v[b] = 1'b0;
         else if (RO[i] || dir_in[i]) v[b] = pins[i] & ~analog_sel[i];
         else v[b] = mdl[p][b];
      end
      return v;
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic byte_wr(input logic [AW-1:0] a, input logic [7:0] d);
      int p;
      logic [7:0] wm;
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
      p = port_of(a);
      if (p >= 0) begin
         wm = IMPL[p*8 +: 8] & ~RO[p*8 +: 8];
         mdl[p] = (mdl[p] & ~wm) | (d & wm);
      end
   endtask

   task automatic bit_write(input logic [AW-1:0] a, input int idx, input logic v);
      int p;
      @(negedge clk);
      addr = a; bit_idx = 3'(idx); bit_val = v; bit_wr = 1'b1;
      @(posedge clk);
      #1 bit_wr = 1'b0;
      p = port_of(a);
      if (p >= 0) begin
         if (IMPL[p*8 + idx] && !RO[p*8 + idx]) mdl[p][idx] = v;
      end
   endtask

   task automatic check_read(input string tag, input logic [AW-1:0] a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 check8(tag, rd_data, exp_rd(a, pin_in));
      rd_en = 1'b0;
   endtask

   task automatic check_latches(input string tag);
      for (int p = 0; p < NP; p++) check8(tag, latch_out[p*8 +: 8], mdl[p]);
   endtask

   task automatic read_all(input string tag);
      for (int a = int'(BASE) - 1; a <= int'(BASE) + NP; a++) check_read(tag, AW'(a));
   endtask

   task automatic settle_pins(input logic [NP*8-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [7:0] pats [5];
      logic [7:0] old_v;
      logic [7:0] new_v;
      pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h5A; pats[3] = 8'h00; pats[4] = 8'h3C;
      for (int p = 0; p < NP; p++) mdl[p] = 8'h00;
      rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; bit_wr = 1'b0;
      bit_idx = '0; bit_val = 1'b0; rd_en = 1'b0;
      dir_in = '0; analog_sel = '0; pin_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_latches("R1 latch after reset");
      read_all("R1 read after reset");

      // R2 R3 R7 R8 R9 R10: byte writes swept over every address, output mode
      settle_pins({NP*8{1'b1}});
      for (int a = int'(BASE) - 2; a <= int'(BASE) + NP + 1; a++) begin
         for (int k = 0; k < 5; k++) begin
            byte_wr(AW'(a), pats[k] ^ 8'(a));
            check_latches("R2 R7 R8 R9 latch after byte write");
            read_all("R3 R7 R8 R9 R10 read after byte write");
         end
      end

      // R6: single-bit writes
      for (int p = 0; p < NP; p++) begin
         for (int i = 0; i < 8; i++) begin
            bit_write(AW'(int'(BASE) + p), i, 1'((i + p) & 1));
            check_latches("R6 latch after bit write");
            check_read("R6 read after bit write", AW'(int'(BASE) + p));
            bit_write(AW'(int'(BASE) + p), i, 1'(~((i + p) & 1)));
            check_latches("R6 latch after bit flip");
         end
      end

      // R2: byte and bit strobes together, byte write wins
      byte_wr(BASE + 8'd1, 8'h0F);
      @(negedge clk);
      addr = BASE + 8'd1; wr_data = 8'hF0; wr_en = 1'b1;
      bit_idx = 3'd0; bit_val = 1'b1; bit_wr = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0; bit_wr = 1'b0;
      mdl[1] = 8'hF0;
      check_latches("R2 byte write over bit write");

      // R4: input mode and synchronizer delay
      dir_in = {NP*8{1'b1}};
      foreach (pats[k]) begin
         settle_pins({NP{pats[k]}} ^ 32'hC33C_0FF0);
         read_all("R4 R8 input-mode read");
      end
      settle_pins(32'h0000_0000);
      old_v = exp_rd(BASE + 8'd1, 32'h0000_0000);
      new_v = exp_rd(BASE + 8'd1, 32'h0000_A500);
      @(negedge clk);
      pin_in = 32'h0000_A500; addr = BASE + 8'd1; rd_en = 1'b1;
      #1 check8("R4 pin change, no edge", rd_data, old_v);
      @(negedge clk);
      #1 check8("R4 pin change, one edge", rd_data, old_v);
      @(negedge clk);
      #1 check8("R4 pin change, two edges", rd_data, new_v);
      rd_en = 1'b0;

      // R5: analog select with mixed directions
      for (int p = 0; p < NP; p++) byte_wr(AW'(int'(BASE) + p), 8'hFF);
      dir_in = 32'h0F0F_F0F0;
      settle_pins({NP*8{1'b1}});
      analog_sel = {NP*8{1'b1}};
      read_all("R5 analog all");
      analog_sel = 32'h55AA_55AA;
      read_all("R5 analog mixed");
      analog_sel = '0;
      read_all("R5 analog clear");

      // R11: no read strobe, data stays zero
      @(negedge clk);
      addr = BASE; rd_en = 1'b0;
      #1 check8("R11 idle read data", rd_data, 8'h00);

      report();
   end
endmodule